// File: doc/BRIEF.md
# Scatter-Gather DMA Control Registers

This block is the host-facing control front end of a scatter-gather DMA engine serving one storage channel. Software reaches it through a small byte-addressed register window. The window holds a command byte, a status byte and a 32-bit pointer to the descriptor table in memory. Each access moves 1, 2 or 4 bytes. The block turns edges of the command's run bit into one-cycle strobes for the engine, and it keeps the table pointer the engine walks.

A stop request never cuts a transfer short. If the engine is mid-transfer, the active flag stays set until the engine goes idle. The drive's interrupt line passes straight through to the host. Only its rising edge is recorded in the status byte, where software clears it by writing a one.

Top module: `sg_dma_ctl`

## Requirements
- R1: The command byte sits at window offset 0. Only bit 0 (run) and bit 3 (direction) are stored, and every other bit reads back as 0. The direction bit drives `eng_dir`.
- R2: A command write whose run bit equals the stored run bit raises neither `eng_kick` nor `eng_reload`. It leaves `eng_ptr` and `eng_active` unchanged, and it updates only the direction bit.
- R3: A command write that takes run from 0 to 1 does three things in the next cycle. It loads `eng_ptr` from the table base and pulses `eng_reload` for one cycle. If active was clear, it also sets active and pulses `eng_kick` for one cycle. If active was already set, it pulses no kick.
- R4: A command write that takes run from 1 to 0 behaves in one of two ways. If `eng_busy` is high, active stays set for as long as `eng_busy` stays high, and it clears in the cycle after `eng_busy` falls. If `eng_busy` is low, active clears in the next cycle. A 0-to-1 write made while the stop is still waiting withdraws the stop.
- R5: The table base occupies offsets 4 to 7, little-endian. `reg_size` values 0, 1 and 2 select 1, 2 and 4 bytes, starting at `reg_addr`. A write replaces only the bytes it covers, and base bits [1:0] are always 0.
- R6: `reg_rdata` returns the window bytes starting at `reg_addr`, aligned to bit 0. Bytes beyond the access width read as 0.
- R7: `host_irq` follows `drv_irq` in the same cycle. A rising edge of `drv_irq` sets status bit 2 in the next cycle, and a falling edge leaves status bit 2 unchanged.
- R8: The status byte sits at offset 2. Writing 1 to bit 1 or bit 2 clears that bit, and writing 0 has no effect. Bit 0 (active) ignores writes, and bits 7:3 read 0.
- R9: An `eng_done` pulse with `eng_more` low clears active. An `eng_done` pulse with `eng_more` high leaves active set.
- R10: An `eng_fetch` pulse advances `eng_ptr` by 8 (one descriptor).
- R11: Reset clears command, status, base, `eng_ptr`, active and any pending stop.
- R12: An `eng_err` pulse sets status bit 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Byte offset of the access in the window |
| reg_size | input | 2 | Access width: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| reg_wdata | input | 32 | Write data, byte 0 at bits 7:0 |
| reg_rdata | output | 32 | Read data for the addressed bytes |
| eng_busy | input | 1 | Engine has a transfer in flight |
| eng_done | input | 1 | Engine completion pulse |
| eng_more | input | 1 | Qualifies `eng_done`: more work remains |
| eng_fetch | input | 1 | Engine consumed one descriptor |
| eng_err | input | 1 | Engine error pulse |
| eng_kick | output | 1 | One-cycle start strobe to the engine |
| eng_reload | output | 1 | One-cycle strobe: pointer reloaded from base |
| eng_dir | output | 1 | Stored direction bit |
| eng_active | output | 1 | Status active flag |
| eng_ptr | output | 32 | Current descriptor pointer |
| drv_irq | input | 1 | Interrupt from the drive |
| host_irq | output | 1 | Interrupt to the host |

## Verification
The bench builds the block with its default parameters: an 8-byte window, a 32-bit base and a descriptor stride of 8. With these values the full space of offset and width combinations over the base bytes is only 12 pairs. The bench writes every one of them and reads back every one of them, predicting each result with byte arithmetic. The same small configuration lets the bench walk every run-bit transition against each engine state: idle, busy, stop pending and already active. It also covers interrupt edges against write-one-to-clear writes.

// File: rtl/sg_dma_ctl_pkg.sv
package sg_dma_ctl_pkg;
    localparam int WIN_BYTES   = 8;
    localparam int OFS_CMD     = 0;
    localparam int OFS_STAT    = 2;
    localparam int OFS_BASE    = 4;
    localparam int CMD_RUN_BIT = 0;
    localparam int CMD_DIR_BIT = 3;
    localparam int ST_ACT_BIT  = 0;
    localparam int ST_ERR_BIT  = 1;
    localparam int ST_INT_BIT  = 2;

    typedef struct packed {
        logic irq_prev;
        logic int_flag;
        logic err_flag;
    } irq_state_t;
endpackage

// File: rtl/sg_dma_lane_map.sv
module sg_dma_lane_map #(
    parameter int WIN = 8,
    parameter int DW  = 32,
    localparam int AW = $clog2(WIN),
    localparam int WB = WIN * 8,
    localparam int DB = DW / 8
) (
    input  logic [AW-1:0]  addr,
    input  logic [1:0]     size,
    input  logic [DW-1:0]  wdata,
    input  logic [WB-1:0]  window,
    output logic [WIN-1:0] lane_we,
    output logic [WB-1:0]  lane_wd,
    output logic [DW-1:0]  rdata
);
    int             nbytes;
    logic [WIN-1:0] byte_mask;
    logic [WB-1:0]  shifted;

    always_comb begin
        case (size)
            2'd0:    nbytes = 1;
            2'd1:    nbytes = 2;
            default: nbytes = DB;
        endcase
        byte_mask = '0;
        for (int i = 0; i < DB; i++) begin
            if (i < nbytes) byte_mask[i] = 1'b1;
        end
        lane_we = byte_mask << addr;
        lane_wd = WB'(wdata) << (8 * addr);
        shifted = window >> (8 * addr);
        rdata   = '0;
        for (int i = 0; i < DB; i++) begin
            if (i < nbytes) rdata[8*i +: 8] = shifted[8*i +: 8];
        end
    end
endmodule

// File: rtl/sg_dma_run_ctrl.sv
module sg_dma_run_ctrl #(
    parameter int PW     = 32,
    parameter int STRIDE = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_we,
    input  logic          cmd_run_wr,
    input  logic          cmd_dir_wr,
    input  logic [PW-1:0] base,
    input  logic          eng_busy,
    input  logic          eng_done,
    input  logic          eng_more,
    input  logic          eng_fetch,
    output logic          run,
    output logic          dir,
    output logic          active,
    output logic          kick,
    output logic          reload,
    output logic [PW-1:0] ptr
);
    typedef struct packed {
        logic          run;
        logic          dir;
        logic          active;
        logic          stop_pend;
        logic          kick;
        logic          reload;
        logic [PW-1:0] ptr;
    } run_state_t;

    run_state_t run_d, run_q;

    always_comb begin
        run_d        = run_q;
        run_d.kick   = 1'b0;
        run_d.reload = 1'b0;
        if (eng_fetch) run_d.ptr = run_q.ptr + PW'(STRIDE);
        if (eng_done)  run_d.active = eng_more;
        if (run_q.stop_pend && !eng_busy) begin
            run_d.active    = 1'b0;
            run_d.stop_pend = 1'b0;
        end
        if (cmd_we) begin
            run_d.dir = cmd_dir_wr;
            run_d.run = cmd_run_wr;
            if (cmd_run_wr != run_q.run) begin
                if (cmd_run_wr) begin
                    run_d.ptr       = base;
                    run_d.reload    = 1'b1;
                    run_d.stop_pend = 1'b0;
                    if (!run_q.active) begin
                        run_d.active = 1'b1;
                        run_d.kick   = 1'b1;
                    end
                end else if (eng_busy) begin
                    run_d.stop_pend = 1'b1;
                end else begin
                    run_d.active    = 1'b0;
                    run_d.stop_pend = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_d;
    end

    assign run    = run_q.run;
    assign dir    = run_q.dir;
    assign active = run_q.active;
    assign kick   = run_q.kick;
    assign reload = run_q.reload;
    assign ptr    = run_q.ptr;

    // R2
    same_run_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_we && (cmd_run_wr == run_q.run) |=> !run_q.kick && !run_q.reload);

    // R3
    rise_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_we && cmd_run_wr && !run_q.run |=> run_q.reload && (run_q.ptr == $past(base)));

    // R4
    stop_waits_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_q.stop_pend && eng_busy && !eng_done && !cmd_we |=> run_q.active == $past(run_q.active));

    // R9
    done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done && !eng_more && !cmd_we && !run_q.stop_pend |=> !run_q.active);

    // R10
    fetch_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_fetch && !cmd_we |=> run_q.ptr == $past(run_q.ptr) + PW'(STRIDE));
endmodule

// File: rtl/sg_dma_irq_latch.sv
module sg_dma_irq_latch
    import sg_dma_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic irq_in,
    input  logic eng_err,
    input  logic clr_int,
    input  logic clr_err,
    output logic int_flag,
    output logic err_flag,
    output logic irq_out
);
    irq_state_t irq_d, irq_q;

    always_comb begin
        irq_d          = irq_q;
        irq_d.irq_prev = irq_in;
        if (clr_int) irq_d.int_flag = 1'b0;
        if (clr_err) irq_d.err_flag = 1'b0;
        if (irq_in && !irq_q.irq_prev) irq_d.int_flag = 1'b1;
        if (eng_err) irq_d.err_flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_d;
    end

    assign int_flag = irq_q.int_flag;
    assign err_flag = irq_q.err_flag;
    assign irq_out  = irq_in;

    // R7
    rise_sets_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_in && !irq_q.irq_prev |=> irq_q.int_flag);

    // R7
    low_keeps_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_in && !clr_int |=> irq_q.int_flag == $past(irq_q.int_flag));

    // R8
    w1c_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_int && !(irq_in && !irq_q.irq_prev) |=> !irq_q.int_flag);

    // R12
    err_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_err |=> irq_q.err_flag);
endmodule

// File: rtl/sg_dma_ctl.sv
module sg_dma_ctl
    import sg_dma_ctl_pkg::*;
#(
    parameter int WIN    = WIN_BYTES,
    parameter int DW     = 32,
    parameter int STRIDE = 8,
    localparam int AW    = $clog2(WIN),
    localparam int WB    = WIN * 8,
    localparam int DB    = DW / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [1:0]    reg_size,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          eng_busy,
    input  logic          eng_done,
    input  logic          eng_more,
    input  logic          eng_fetch,
    input  logic          eng_err,
    output logic          eng_kick,
    output logic          eng_reload,
    output logic          eng_dir,
    output logic          eng_active,
    output logic [DW-1:0] eng_ptr,
    input  logic          drv_irq,
    output logic          host_irq
);
    logic [WIN-1:0] lane_we;
    logic [WIN-1:0] wr_lane;
    logic [WB-1:0]  lane_wd;
    logic [WB-1:0]  window;
    logic [DW-1:0]  base_d, base_q;
    logic           run, int_flag, err_flag;
    logic [7:0]     cmd_wbyte, stat_wbyte;
    logic           unused_lanes;

    sg_dma_lane_map #(.WIN(WIN), .DW(DW)) lane_i (
        .addr    (reg_addr),
        .size    (reg_size),
        .wdata   (reg_wdata),
        .window  (window),
        .lane_we (lane_we),
        .lane_wd (lane_wd),
        .rdata   (reg_rdata)
    );

    assign wr_lane      = lane_we & {WIN{reg_wr}};
    assign cmd_wbyte    = lane_wd[8*OFS_CMD +: 8];
    assign stat_wbyte   = lane_wd[8*OFS_STAT +: 8];
    assign unused_lanes = ^{lane_wd, wr_lane};

    always_comb begin
        base_d = base_q;
        for (int j = 0; j < DB; j++) begin
            if (wr_lane[OFS_BASE + j]) base_d[8*j +: 8] = lane_wd[8*(OFS_BASE + j) +: 8];
        end
        base_d[1:0] = 2'b00;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) base_q <= '0;
        else        base_q <= base_d;
    end

    sg_dma_run_ctrl #(.PW(DW), .STRIDE(STRIDE)) run_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_we     (wr_lane[OFS_CMD]),
        .cmd_run_wr (cmd_wbyte[CMD_RUN_BIT]),
        .cmd_dir_wr (cmd_wbyte[CMD_DIR_BIT]),
        .base       (base_q),
        .eng_busy   (eng_busy),
        .eng_done   (eng_done),
        .eng_more   (eng_more),
        .eng_fetch  (eng_fetch),
        .run        (run),
        .dir        (eng_dir),
        .active     (eng_active),
        .kick       (eng_kick),
        .reload     (eng_reload),
        .ptr        (eng_ptr)
    );

    sg_dma_irq_latch irq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_in   (drv_irq),
        .eng_err  (eng_err),
        .clr_int  (wr_lane[OFS_STAT] && stat_wbyte[ST_INT_BIT]),
        .clr_err  (wr_lane[OFS_STAT] && stat_wbyte[ST_ERR_BIT]),
        .int_flag (int_flag),
        .err_flag (err_flag),
        .irq_out  (host_irq)
    );

    always_comb begin
        window = '0;
        window[8*OFS_CMD + CMD_RUN_BIT]  = run;
        window[8*OFS_CMD + CMD_DIR_BIT]  = eng_dir;
        window[8*OFS_STAT + ST_ACT_BIT]  = eng_active;
        window[8*OFS_STAT + ST_ERR_BIT]  = err_flag;
        window[8*OFS_STAT + ST_INT_BIT]  = int_flag;
        window[8*OFS_BASE +: DW]         = base_q;
    end

    // R5
    base_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> base_q[1:0] == 2'b00);

    // R7
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq == drv_irq);
endmodule

// File: tb/sg_dma_ctl_tb.sv
module sg_dma_ctl_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [1:0]  reg_size = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        eng_busy = 1'b0, eng_done = 1'b0, eng_more = 1'b0;
    logic        eng_fetch = 1'b0, eng_err = 1'b0;
    logic        eng_kick, eng_reload, eng_dir, eng_active, host_irq;
    logic [31:0] eng_ptr;
    logic        drv_irq = 1'b0;

    int          n_checks = 0;
    int          n_errors = 0;
    logic [31:0] exp_base = '0;
    logic [31:0] rd_val;

    always #(CLK_PERIOD/2) clk = ~clk;

    sg_dma_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_size(reg_size), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eng_busy(eng_busy), .eng_done(eng_done), .eng_more(eng_more),
        .eng_fetch(eng_fetch), .eng_err(eng_err), .eng_kick(eng_kick),
        .eng_reload(eng_reload), .eng_dir(eng_dir), .eng_active(eng_active),
        .eng_ptr(eng_ptr), .drv_irq(drv_irq), .host_irq(host_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int sz, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a[2:0]; reg_size = sz[1:0]; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, input int sz, output logic [31:0] d);
        reg_addr = a[2:0]; reg_size = sz[1:0];
        #1 d = reg_rdata;
    endtask

    task automatic eng_pulse(input logic done, input logic more, input logic fetch, input logic err);
        eng_done = done; eng_more = more; eng_fetch = fetch; eng_err = err;
        @(negedge clk);
        eng_done = 1'b0; eng_more = 1'b0; eng_fetch = 1'b0; eng_err = 1'b0;
    endtask

    function automatic logic [31:0] width_mask(input int sz);
        return (sz >= 2) ? 32'hFFFF_FFFF : ((32'h1 << (8 << sz)) - 1);
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        rd(0, 2, rd_val); check("R11 cmd/status", rd_val, 32'h0);
        rd(4, 2, rd_val); check("R11 base", rd_val, 32'h0);
        check("R11 ptr", eng_ptr, 32'h0);
        check("R11 active", {31'h0, eng_active}, 32'h0);

        // R5/R6: every offset/width over the base bytes, model merged byte-wise
        for (int a = 4; a < 8; a++) begin
            for (int sz = 0; sz < 3; sz++) begin
                logic [31:0] d;
                d = {8'(a * 17 + sz), 8'(8'hC3 ^ 8'(a)), 8'(8'h5A + 8'(sz * 9)), 8'(8'hF7 - 8'(a))};
                wr(a, sz, d);
                for (int j = 0; j < (1 << sz); j++) begin
                    if (a + j < 8) exp_base[8*(a + j - 4) +: 8] = d[8*j +: 8];
                end
                exp_base[1:0] = 2'b00;
                rd(4, 2, rd_val); check("R5 base merge", rd_val, exp_base);
                for (int ra = 4; ra < 8; ra++) begin
                    for (int rs = 0; rs < 3; rs++) begin
                        rd(ra, rs, rd_val);
                        check("R6 aligned read", rd_val, (exp_base >> (8 * (ra - 4))) & width_mask(rs));
                    end
                end
            end
        end

        wr(4, 2, 32'hA5A5_5A5F);
        exp_base = 32'hA5A5_5A5C;
        rd(4, 2, rd_val); check("R5 low bits zero", rd_val, exp_base);

        // R1 + R3: run 0->1 with stray bits
        wr(0, 0, 32'h0000_00FF);
        rd(0, 0, rd_val); check("R1 cmd bits", rd_val, 32'h09);
        check("R1 dir out", {31'h0, eng_dir}, 32'h1);
        check("R3 kick", {31'h0, eng_kick}, 32'h1);
        check("R3 reload", {31'h0, eng_reload}, 32'h1);
        check("R3 ptr", eng_ptr, exp_base);
        check("R3 active", {31'h0, eng_active}, 32'h1);
        @(negedge clk);
        check("R3 kick single", {31'h0, eng_kick}, 32'h0);

        // R10 fetch advance
        eng_pulse(1'b0, 1'b0, 1'b1, 1'b0);
        check("R10 ptr step", eng_ptr, exp_base + 32'd8);
        eng_pulse(1'b0, 1'b0, 1'b1, 1'b0);
        check("R10 ptr step2", eng_ptr, exp_base + 32'd16);

        // R2: same run bit, dir cleared
        wr(0, 0, 32'h01);
        check("R2 no kick", {31'h0, eng_kick}, 32'h0);
        check("R2 no reload", {31'h0, eng_reload}, 32'h0);
        check("R2 ptr kept", eng_ptr, exp_base + 32'd16);
        check("R2 active kept", {31'h0, eng_active}, 32'h1);
        rd(0, 0, rd_val); check("R2 dir updated", rd_val, 32'h01);

        // R9 completion
        eng_pulse(1'b1, 1'b1, 1'b0, 1'b0);
        check("R9 more keeps active", {31'h0, eng_active}, 32'h1);
        eng_pulse(1'b1, 1'b0, 1'b0, 1'b0);
        check("R9 done clears", {31'h0, eng_active}, 32'h0);
        rd(2, 0, rd_val); check("R9 status bit0", rd_val, 32'h0);

        // R4: stop when idle, then stop while busy
        wr(0, 0, 32'h00);
        check("R4 idle stop", {31'h0, eng_active}, 32'h0);
        wr(0, 0, 32'h01);
        check("R3 restart kick", {31'h0, eng_kick}, 32'h1);
        check("R3 restart ptr", eng_ptr, exp_base);
        eng_busy = 1'b1;
        wr(0, 0, 32'h00);
        check("R4 held while busy", {31'h0, eng_active}, 32'h1);
        repeat (3) @(negedge clk);
        check("R4 still held", {31'h0, eng_active}, 32'h1);
        eng_busy = 1'b0;
        @(negedge clk);
        check("R4 clears after idle", {31'h0, eng_active}, 32'h0);

        // R3/R4: re-run while stop pending withdraws the stop, no kick
        wr(0, 0, 32'h01);
        eng_busy = 1'b1;
        wr(0, 0, 32'h00);
        wr(4, 2, 32'h0000_1000);
        exp_base = 32'h0000_1000;
        wr(0, 0, 32'h01);
        check("R3 no kick when active", {31'h0, eng_kick}, 32'h0);
        check("R3 reload when active", {31'h0, eng_reload}, 32'h1);
        check("R3 new base", eng_ptr, exp_base);
        eng_busy = 1'b0;
        repeat (2) @(negedge clk);
        check("R4 stop withdrawn", {31'h0, eng_active}, 32'h1);
        eng_pulse(1'b1, 1'b0, 1'b0, 1'b0);

        // R7 interrupt
        drv_irq = 1'b1;
        #1 check("R7 pass high", {31'h0, host_irq}, 32'h1);
        @(negedge clk);
        rd(2, 0, rd_val); check("R7 int set", rd_val, 32'h04);
        drv_irq = 1'b0;
        #1 check("R7 pass low", {31'h0, host_irq}, 32'h0);
        @(negedge clk);
        rd(2, 0, rd_val); check("R7 int kept", rd_val, 32'h04);

        // R8 write-one-to-clear
        wr(2, 0, 32'h00);
        rd(2, 0, rd_val); check("R8 zero no effect", rd_val, 32'h04);
        wr(2, 0, 32'hF9);
        rd(2, 0, rd_val); check("R8 bit0 ignored", rd_val, 32'h04);
        wr(2, 0, 32'h04);
        rd(2, 0, rd_val); check("R8 int cleared", rd_val, 32'h00);

        // R12 error flag
        eng_pulse(1'b0, 1'b0, 1'b0, 1'b1);
        rd(2, 0, rd_val); check("R12 err set", rd_val, 32'h02);
        wr(2, 0, 32'h02);
        rd(2, 0, rd_val); check("R8 err cleared", rd_val, 32'h00);

        // R11 reset during activity
        wr(0, 0, 32'h00);
        wr(0, 0, 32'h09);
        eng_pulse(1'b0, 1'b0, 1'b0, 1'b1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(0, 2, rd_val); check("R11 cmd/status cleared", rd_val, 32'h0);
        rd(4, 2, rd_val); check("R11 base cleared", rd_val, 32'h0);
        check("R11 ptr cleared", eng_ptr, 32'h0);
        check("R11 active cleared", {31'h0, eng_active}, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule